// File: doc/BRIEF.md
# Burst Transmit Timing Controller

This block sits at the front of a 384 kbit/s burst modulator. It derives a bit clock from one of two external sources, collects serial transmit bits into two-bit symbols, and frames each burst for a pulse-shaping stage further down the chain. The framing is given as three phase flags: ramp-up, data and ramp-down. The frame lags the transmit window by the latency of the shaping pipeline, and a ramp of fixed length is added on each side of the data.

All inputs are synchronous to the system clock `clk`. The external clock is sampled on `clk`, and its edges act as timing events. With `clk_sel` = 1 the input is a 3.84 MHz clock, divided by ten on chip. With `clk_sel` = 0 the input is already the 384 kHz bit clock.

Both edges of the bit clock are "half-bit ticks". One half-bit tick equals a quarter of a symbol, and all burst framing is counted in these ticks. The 6.25-symbol lag is 25 ticks, and each 2-symbol ramp is 8 ticks.

The bit clock output can carry the burst envelope in place of the clock, so that an external radio can see where the burst sits in time.

Top module: `burst_tx_timer`

## Requirements
- R1: With `clk_sel`=1, `bit_clk_out` is the external clock divided by 10. It goes high on the 1st rising input edge after reset, falls on the 6th, and then repeats every 10 rising edges. A half-bit tick occurs on each of its edges.
- R2: With `clk_sel`=0, `bit_clk_out` follows `ext_clk` one `clk` cycle late. Each edge of `ext_clk` is a half-bit tick.
- R3: On each rising bit-clock edge while `tx_win`=1, `tx_data` is captured.
  - The first captured bit goes to `sym_bits[1]`, and the second bit of the pair goes to `sym_bits[0]`.
  - `sym_strobe` pulses for exactly one `clk` cycle, in the cycle after the second bit is captured.
  - A rising edge with `tx_win`=0 discards any unpaired bit.
- R4: While `mod_off`=1, every strobed symbol is `2'b00`, whatever the data bits are.
- R5: `data_valid` equals the value of `tx_win` sampled 25 half-bit ticks earlier. The flags change only in the cycle after a half-bit tick.
- R6: `ramp_up` is 1 when `tx_win` was 1 at 17 ticks back and 0 at 25 ticks back. It therefore leads the data by 8 ticks (2 symbols).
- R7: `ramp_down` is 1 during the 8 ticks after `data_valid` falls, except while `ramp_up` or `data_valid` is 1.
- R8: The three flags are never active together. If the window returns during a ramp-down, `ramp_up` takes over at once.
- R9: With `burst_pos_en`=1 and `clk_sel`=0, `bit_clk_out` equals the OR of the three flags. With `clk_sel`=1, `burst_pos_en` has no effect.
- R10: After reset, all flags, `sym_strobe` and `bit_clk_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | 1: divide external clock by 10; 0: external clock is the bit clock |
| ext_clk | input | 1 | External transmit clock, sampled on clk |
| tx_data | input | 1 | Serial transmit data |
| tx_win | input | 1 | Transmit window |
| mod_off | input | 1 | Forces a fixed symbol of 00 |
| burst_pos_en | input | 1 | Replaces bit_clk_out with the burst envelope in direct mode |
| bit_clk_out | output | 1 | Bit clock, or burst position |
| ramp_up | output | 1 | Ramp-up phase flag |
| data_valid | output | 1 | Data phase flag |
| ramp_down | output | 1 | Ramp-down phase flag |
| sym_strobe | output | 1 | One-cycle pulse when a symbol is ready |
| sym_bits | output | 2 | Symbol, first bit in the MSB |

## Verification
The bench sweeps window lengths from one bit to several symbols against gaps of one to five bits, in both clock modes. Short gaps force a new ramp-up while a ramp-down is still running. A design that let ramp-down win, or counted the ramp from the data edge, would show two flags at once or lose the ramp-up. Windows with an odd number of bits check that a leftover bit is thrown away. A design that kept it would pair that bit with the first bit of the next burst and strobe a wrong symbol. In divided mode the bench tracks the bit clock level at every tick, which catches a wrong reset phase or a wrong divisor. The burst-position sweep covers both modes, which catches a design that switches the output in the wrong mode.

// File: rtl/burst_tx_timer.sv
module burst_tx_timer #(
  parameter int DIV      = 10,
  parameter int DELAY_QS = 25,
  parameter int RAMP_QS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_sel,
  input  logic       ext_clk,
  input  logic       tx_data,
  input  logic       tx_win,
  input  logic       mod_off,
  input  logic       burst_pos_en,
  output logic       bit_clk_out,
  output logic       ramp_up,
  output logic       data_valid,
  output logic       ramp_down,
  output logic       sym_strobe,
  output logic [1:0] sym_bits
);

  localparam int HALF   = DIV / 2;
  localparam int CW     = $clog2(DIV);
  localparam int UP_TAP = DELAY_QS - RAMP_QS;
  localparam int DEPTH  = DELAY_QS + RAMP_QS + 1;

  logic          ext_q;
  logic [CW-1:0] div_cnt;
  logic [DEPTH-1:0] win_sh;
  logic          pair_half, pair_first;

  wire ext_rise = ext_clk & ~ext_q;
  wire ext_fall = ~ext_clk & ext_q;
  wire div_wrap = (div_cnt == CW'(DIV - 1));
  wire div_mid  = (div_cnt == CW'(HALF - 1));

  wire bit_rise = clk_sel ? (ext_rise & div_wrap) : ext_rise;
  wire bit_fall = clk_sel ? (ext_rise & div_mid)  : ext_fall;
  wire qs_tick  = bit_rise | bit_fall;

  wire bit_clk  = clk_sel ? (div_cnt < CW'(HALF)) : ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= 1'b0;
      div_cnt <= CW'(DIV - 1);
    end else begin
      ext_q <= ext_clk;
      if (ext_rise) div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       win_sh <= '0;
    else if (qs_tick) win_sh <= {win_sh[DEPTH-2:0], tx_win};
  end

  assign data_valid = win_sh[DELAY_QS];
  assign ramp_up    = win_sh[UP_TAP] & ~win_sh[DELAY_QS];
  assign ramp_down  = ~ramp_up & ~win_sh[DELAY_QS] & (|win_sh[DEPTH-1:DELAY_QS+1]);

  wire burst_env = ramp_up | data_valid | ramp_down;
  assign bit_clk_out = (burst_pos_en & ~clk_sel) ? burst_env : bit_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_half  <= 1'b0;
      pair_first <= 1'b0;
      sym_strobe <= 1'b0;
      sym_bits   <= 2'b00;
    end else begin
      sym_strobe <= 1'b0;
      if (bit_rise) begin
        if (!tx_win) begin
          pair_half <= 1'b0;
        end else if (!pair_half) begin
          pair_first <= tx_data;
          pair_half  <= 1'b1;
        end else begin
          pair_half  <= 1'b0;
          sym_strobe <= 1'b1;
          sym_bits   <= mod_off ? 2'b00 : {pair_first, tx_data};
        end
      end
    end
  end

endmodule

// File: rtl/burst_tx_timer_chk.sv
module burst_tx_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       qs_tick,
  input logic       mod_off,
  input logic       ramp_up,
  input logic       data_valid,
  input logic       ramp_down,
  input logic       sym_strobe,
  input logic [1:0] sym_bits
);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ramp_up, data_valid, ramp_down}));

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_strobe |=> !sym_strobe);

  assert_modoff_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_strobe && $past(mod_off)) |-> (sym_bits == 2'b00));

  assert_flags_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(qs_tick) |-> $stable({ramp_up, data_valid, ramp_down}));

  assert_data_end_ramps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_valid) |-> (ramp_down || ramp_up));

endmodule

bind burst_tx_timer burst_tx_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .qs_tick(qs_tick), .mod_off(mod_off),
  .ramp_up(ramp_up), .data_valid(data_valid), .ramp_down(ramp_down),
  .sym_strobe(sym_strobe), .sym_bits(sym_bits)
);

// File: tb/burst_tx_timer_tb.sv
module burst_tx_timer_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, clk_sel, ext_clk, tx_data, tx_win, mod_off, burst_pos_en;
  logic bit_clk_out, ramp_up, data_valid, ramp_down, sym_strobe;
  logic [1:0] sym_bits;

  burst_tx_timer u_dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(ext_clk),
    .tx_data(tx_data), .tx_win(tx_win), .mod_off(mod_off),
    .burst_pos_en(burst_pos_en), .bit_clk_out(bit_clk_out),
    .ramp_up(ramp_up), .data_valid(data_valid), .ramp_down(ramp_down),
    .sym_strobe(sym_strobe), .sym_bits(sym_bits)
  );

  int total = 0;
  int bad = 0;
  int t;
  bit hist [0:4095];
  bit bhalf, bfirst;
  logic [7:0] lfsr = 8'h5a;
  bit done = 0;

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d tick=%0d", req, act, exp, t);
    end
  endtask

  function automatic bit h(int k);
    return (k < 0) ? 1'b0 : hist[k];
  endfunction

  task automatic do_reset(bit sel, bit pos, bit mo);
    @(negedge clk);
    rst_n = 0; clk_sel = sel; burst_pos_en = pos; mod_off = mo;
    ext_clk = 0; tx_data = 0; tx_win = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t = 0; bhalf = 0; bfirst = 0;
    check("R10 flags", {1'b0, ramp_up | data_valid | ramp_down}, 2'd0);
    check("R10 strobe", {1'b0, sym_strobe}, 2'd0);
    check("R10 clk_out", {1'b0, bit_clk_out}, 2'd0);
  endtask

  task automatic half_bit(bit rising);
    bit ed, eu, en, eclk, es;
    logic [1:0] eb;
    @(negedge clk) ext_clk = clk_sel ? 1'b1 : rising;
    @(negedge clk);
    hist[t] = tx_win;
    ed = h(t - 25);
    eu = h(t - 17) & !ed;
    en = 0;
    for (int k = 26; k <= 33; k++) en |= h(t - k);
    en = en & !eu & !ed;
    check("R5 data_valid", {1'b0, data_valid}, {1'b0, ed});
    check("R6 ramp_up", {1'b0, ramp_up}, {1'b0, eu});
    check("R7 R8 ramp_down", {1'b0, ramp_down}, {1'b0, en});
    eclk = (burst_pos_en && !clk_sel) ? (eu | ed | en) : rising;
    check(burst_pos_en ? "R9 clk_out" : (clk_sel ? "R1 clk_out" : "R2 clk_out"),
          {1'b0, bit_clk_out}, {1'b0, eclk});
    es = 0; eb = 2'b00;
    if (rising) begin
      if (!tx_win) bhalf = 0;
      else if (!bhalf) begin bfirst = tx_data; bhalf = 1; end
      else begin
        es = 1; bhalf = 0;
        eb = mod_off ? 2'b00 : {bfirst, tx_data};
      end
    end
    check("R3 strobe", {1'b0, sym_strobe}, {1'b0, es});
    if (es) check(mod_off ? "R4 bits" : "R3 bits", sym_bits, eb);
    t++;
    if (clk_sel) begin
      ext_clk = 0;
      repeat (4) begin
        @(negedge clk) ext_clk = 1;
        @(negedge clk) ext_clk = 0;
      end
    end else begin
      @(negedge clk);
    end
  endtask

  task automatic send_bit(bit w, bit d);
    tx_win = w; tx_data = d;
    half_bit(1);
    half_bit(0);
  endtask

  task automatic burst(int lead, int len, int tail);
    for (int i = 0; i < lead; i++) send_bit(0, 0);
    for (int i = 0; i < len; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      send_bit(1, lfsr[0]);
    end
    for (int i = 0; i < tail; i++) send_bit(0, 0);
  endtask

  task automatic sweep();
    int lens [4] = '{1, 2, 3, 6};
    for (int g = 1; g <= 5; g++)
      for (int li = 0; li < 4; li++) burst(0, lens[li], g);
    burst(0, 0, 20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(0, 0, 0); burst(2, 10, 22);
    do_reset(1, 0, 0); burst(2, 9, 22);
    do_reset(0, 0, 0); sweep();
    do_reset(1, 0, 0); sweep();
    do_reset(0, 1, 0); burst(1, 8, 4); burst(0, 3, 20);
    do_reset(1, 1, 0); burst(1, 8, 20);
    do_reset(0, 0, 1); burst(1, 8, 20);
    do_reset(1, 0, 1); burst(1, 7, 20);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule